// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit pulse generator built around a prescaled up-counter. A period value sets how far the counter runs before it wraps. A duty value sets the count at which the output level flips. Together they form a PWM waveform with up to 16 bits of resolution. The count clock comes from the base clock through a divider chosen from seven ratios.

Software reaches the block through a small word-wide register port. Period and duty writes land in holding registers. These are copied into the active compare registers only when the counter wraps, or at any cycle while the timer is stopped. This means a running waveform never sees a half-updated pair. The block has a free-running mode and a single-pulse mode that stops itself. A polarity bit picks the level at the start of each period, which is also the resting level. There is a counter-restart command and a wrap flag that drives an interrupt request.

Top module: `ppg_timer`

## Requirements
- R1: After reset every register reads 0, the counter reads 0, `pwmOut` is 0 and `irq` is 0.
- R2: Register map, by `addr`: 0 control, 1 clock select, 2 status, 3 period, 4 duty, 5 counter (read only). While running, the counter rises by one on each prescaler tick from 0 up to the active period value P. The tick taken at P returns it to 0, so one period spans P+1 ticks.
- R3: While running, `pwmOut` equals the polarity bit while count < active duty D, and its inverse while count >= D. Two cases follow from this: D = 0 gives the inverted level for the whole period, and D > P gives the polarity level for the whole period.
- R4: Writes to address 3 or 4 update a holding register that reads back at once. The active period and duty take the holding values at a wrap, or on any clock while stopped.
- R5: Clock select (address 1, bits 2:0) chooses the tick divisor: 0→1, 1→2, 2→4, 3→8, 4→32, 5→128, 6 and 7→512. The first tick comes a full divisor of clocks after the run bit is set.
- R6: Control bits 2:1 set the mode: 01 is single-pulse, and any other value repeats. In single-pulse mode, the wrap clears the run bit (control bit 0) and the counter stays at 0.
- R7: With the run bit clear, the counter holds 0 and `pwmOut` rests at the polarity bit (control bit 3).
- R8: Writing 1 to control bit 4 zeroes the counter and the prescaler on the following clock. That bit always reads 0.
- R9: Each wrap sets the status flag (address 2, bit 0). Writing 1 to that bit clears it. When a wrap and a clearing write meet in the same cycle, the flag stays set.
- R10: `irq` is high exactly when the status flag is set and control bit 5 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| pwmOut | output | 1 | Pulse output |
| irq | output | 1 | Interrupt request |

## Verification
The wrap that sets the status flag and a software write that clears it can land on the same clock edge. The bench provokes this with a period of 3 and a divisor of 1, timing a clearing write to finish on the edge of the second wrap. It judges the outcome from `irq` and the status read, which must both stay set. A clearing write one cycle after a wrap is also issued and must drop the flag. A holding-register write in the middle of a period is checked the same way: the old period must still finish before the new one takes hold.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_CLK  = 3'd1,
    ADDR_STAT = 3'd2,
    ADDR_PER  = 3'd3,
    ADDR_DUTY = 3'd4,
    ADDR_CNT  = 3'd5
  } regAddr_e;

  localparam int unsigned MaxShift = 9;

  typedef struct packed {
    logic       run;
    logic       oneShot;
    logic       pol;
    logic       clrCnt;
    logic [2:0] clkSel;
  } ppgStrb_s;

  function automatic int unsigned divShift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 5;
      3'd5:    return 7;
      default: return MaxShift;
    endcase
  endfunction

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
  parameter int PRE_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  import ppg_pkg::*;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << divShift(sel)) - 32'd1);
    tick = run && ((preCnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!run || restart) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppg_pkg::ppgStrb_s strb,
  input  logic [CNT_W-1:0] periodBuf,
  input  logic [CNT_W-1:0] dutyBuf,
  output logic             aMatch,
  output logic             shotDone,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] periodAct,
  output logic             pwmOut
);
  logic             tick;
  logic [CNT_W-1:0] dutyAct;

  ppg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .run    (strb.run),
    .restart(strb.clrCnt),
    .sel    (strb.clkSel),
    .tick   (tick)
  );

  always_comb begin
    aMatch   = tick && !strb.clrCnt && (cnt == periodAct);
    shotDone = aMatch && strb.oneShot;
    pwmOut   = strb.pol ^ (strb.run && (cnt >= dutyAct));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      periodAct <= '0;
      dutyAct   <= '0;
    end else begin
      if (!strb.run || strb.clrCnt) cnt <= '0;
      else if (aMatch)              cnt <= '0;
      else if (tick)                cnt <= cnt + 1'b1;
      if (!strb.run || aMatch) begin
        periodAct <= periodBuf;
        dutyAct   <= dutyBuf;
      end
    end
  end

endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              aMatch,
  input  logic              shotDone,
  input  logic [CNT_W-1:0]  cnt,
  output ppg_pkg::ppgStrb_s strb,
  output logic [CNT_W-1:0]  periodBuf,
  output logic [CNT_W-1:0]  dutyBuf,
  output logic              irqFlag,
  output logic              irq
);
  import ppg_pkg::*;

  logic       runBit, polBit, irqEn, clrPend;
  logic [1:0] mode;
  logic [2:0] clkSel;
  logic       wrCtrl, wrClk, wrStat, wrPer, wrDuty;

  always_comb begin
    wrCtrl = wrEn && (addr == ADDR_CTRL);
    wrClk  = wrEn && (addr == ADDR_CLK);
    wrStat = wrEn && (addr == ADDR_STAT);
    wrPer  = wrEn && (addr == ADDR_PER);
    wrDuty = wrEn && (addr == ADDR_DUTY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      mode      <= 2'b00;
      polBit    <= 1'b0;
      irqEn     <= 1'b0;
      clrPend   <= 1'b0;
      clkSel    <= 3'd0;
      irqFlag   <= 1'b0;
      periodBuf <= '0;
      dutyBuf   <= '0;
    end else begin
      clrPend <= wrCtrl && wrData[4];
      if (wrCtrl) begin
        runBit <= wrData[0];
        mode   <= wrData[2:1];
        polBit <= wrData[3];
        irqEn  <= wrData[5];
      end else if (shotDone) begin
        runBit <= 1'b0;
      end
      if (wrClk)  clkSel    <= wrData[2:0];
      if (wrPer)  periodBuf <= wrData;
      if (wrDuty) dutyBuf   <= wrData;
      if (aMatch)                   irqFlag <= 1'b1;
      else if (wrStat && wrData[0]) irqFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.run     = runBit;
    strb.oneShot = (mode == 2'b01);
    strb.pol     = polBit;
    strb.clrCnt  = clrPend;
    strb.clkSel  = clkSel;
    irq          = irqFlag && irqEn;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[0]   = runBit;
        rdData[2:1] = mode;
        rdData[3]   = polBit;
        rdData[5]   = irqEn;
      end
      ADDR_CLK:  rdData[2:0] = clkSel;
      ADDR_STAT: rdData[0]   = irqFlag;
      ADDR_PER:  rdData      = periodBuf;
      ADDR_DUTY: rdData      = dutyBuf;
      ADDR_CNT:  rdData      = cnt;
      default:   rdData      = '0;
    endcase
  end

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             pwmOut,
  output logic             irq
);
  localparam int PreW = ppg_pkg::MaxShift;

  ppg_pkg::ppgStrb_s strb;
  logic              aMatch, shotDone, irqFlag;
  logic [CNT_W-1:0]  cnt, periodAct, periodBuf, dutyBuf;

  ppg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .aMatch   (aMatch),
    .shotDone (shotDone),
    .cnt      (cnt),
    .strb     (strb),
    .periodBuf(periodBuf),
    .dutyBuf  (dutyBuf),
    .irqFlag  (irqFlag),
    .irq      (irq)
  );

  ppg_datapath #(.CNT_W(CNT_W), .PRE_W(PreW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .periodBuf(periodBuf),
    .dutyBuf  (dutyBuf),
    .aMatch   (aMatch),
    .shotDone (shotDone),
    .cnt      (cnt),
    .periodAct(periodAct),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        addr,
  input ppg_pkg::ppgStrb_s strb,
  input logic              aMatch,
  input logic              shotDone,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  periodAct,
  input logic [CNT_W-1:0]  periodBuf,
  input logic              irqFlag
);
  logic ctrlWrite;
  assign ctrlWrite = wrEn && (addr == 3'd0);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> cnt <= periodAct);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    aMatch |=> cnt == '0);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    aMatch |=> periodAct == $past(periodBuf));

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shotDone && !ctrlWrite) |=> !strb.run);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> cnt == '0);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> cnt == '0);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    aMatch |=> irqFlag);

endmodule

bind ppg_timer ppg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .strb     (strb),
  .aMatch   (aMatch),
  .shotDone (shotDone),
  .cnt      (cnt),
  .periodAct(periodAct),
  .periodBuf(periodBuf),
  .irqFlag  (irqFlag)
);

// File: tb/sim_ppg_timer.sv
`timescale 1ns/1ps
module sim_ppg_timer;
  localparam int W = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_CLK = 3'd1, A_STAT = 3'd2,
                         A_PER = 3'd3, A_DUTY = 3'd4, A_CNT = 3'd5;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic        pol;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd4, 16'd2, 1'b0},
    '{16'd5, 16'd0, 1'b0},
    '{16'd3, 16'd9, 1'b1},
    '{16'd6, 16'd6, 1'b1},
    '{16'd1, 16'd1, 1'b0},
    '{16'd7, 16'd3, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         pwmOut, irq;
  int           nTests = 0;
  int           nFail = 0;

  always #4 clk = ~clk;

  ppg_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    addr = a; #1; v = rdData;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    step(2);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check("R1 pwmOut", W'(pwmOut), 0);
    check("R1 irq", W'(irq), 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PER, v);  check("R1 period", v, 0);
    rd(A_CNT, v);  check("R1 count", v, 0);

    // R3 / R2 vector walk at divisor 1
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, W'({VECS[i].pol, 3'b000}));
      wr(A_PER, VECS[i].per);
      wr(A_DUTY, VECS[i].duty);
      wr(A_CTRL, W'({VECS[i].pol, 3'b001}));
      addr = A_CNT; #1;
      for (int k = 0; k < 2 * (int'(VECS[i].per) + 1); k++) begin
        int c;
        c = k % (int'(VECS[i].per) + 1);
        check("R3 pwm level", W'(pwmOut), W'(VECS[i].pol ^ (c >= int'(VECS[i].duty))));
        check("R2 count", rdData, W'(c));
        step(1);
      end
    end

    // R7 idle level with polarity 1
    wr(A_CTRL, 16'h0008);
    step(1);
    check("R7 idle pwm", W'(pwmOut), 1);
    rd(A_CNT, v); check("R7 idle count", v, 0);

    // R4 buffered reload
    wr(A_CTRL, 16'h0000);
    wr(A_PER, 16'd7);
    wr(A_DUTY, 16'd2);
    wr(A_CTRL, 16'h0001);
    step(2);
    wr(A_PER, 16'd3);
    rd(A_PER, v); check("R4 buffer readback", v, 3);
    step(4);
    rd(A_CNT, v); check("R4 old period still active", v, 7);
    step(4);
    rd(A_CNT, v); check("R4 new period top", v, 3);
    step(1);
    rd(A_CNT, v); check("R4 new period wrap", v, 0);

    // R6 single-pulse
    wr(A_CTRL, 16'h0000);
    wr(A_PER, 16'd2);
    wr(A_DUTY, 16'd1);
    wr(A_CTRL, 16'h0003);
    step(2);
    rd(A_CTRL, v); check("R6 running before wrap", v, 16'h0003);
    step(1);
    rd(A_CTRL, v); check("R6 run cleared", v, 16'h0002);
    rd(A_CNT, v);  check("R6 count zero", v, 0);
    check("R6 pwm idle", W'(pwmOut), 0);
    step(2);
    rd(A_CNT, v);  check("R6 count stays", v, 0);

    // R10 gating, R9 set/clear/collision
    wr(A_CTRL, 16'h0000);
    rd(A_STAT, v); check("R10 flag left set", v, 1);
    check("R10 irq gated off", W'(irq), 0);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, v); check("R9 flag cleared", v, 0);
    wr(A_PER, 16'd3);
    wr(A_DUTY, 16'd1);
    wr(A_CTRL, 16'h0021);
    step(4);
    check("R9 irq after wrap", W'(irq), 1);
    wr(A_STAT, 16'h0001);
    check("R9 irq cleared", W'(irq), 0);
    step(2);
    wr(A_STAT, 16'h0001);
    check("R9 set wins over clear", W'(irq), 1);
    rd(A_STAT, v); check("R9 flag after collision", v, 1);

    // R5 divisor 4, then R8 restart
    wr(A_CTRL, 16'h0000);
    wr(A_CLK, 16'd2);
    wr(A_PER, 16'd100);
    wr(A_CTRL, 16'h0001);
    step(7);
    rd(A_CNT, v); check("R5 div4 first tick", v, 1);
    step(1);
    rd(A_CNT, v); check("R5 div4 second tick", v, 2);
    wr(A_CTRL, 16'h0011);
    step(1);
    rd(A_CNT, v);  check("R8 count restarted", v, 0);
    rd(A_CTRL, v); check("R8 clear reads 0", v, 16'h0001);
    step(3);
    rd(A_CNT, v); check("R8 prescaler restarted", v, 0);
    step(1);
    rd(A_CNT, v); check("R8 first tick after restart", v, 1);

    // R5 divisor 32
    wr(A_CTRL, 16'h0000);
    wr(A_CLK, 16'd4);
    wr(A_CTRL, 16'h0001);
    step(31);
    rd(A_CNT, v); check("R5 div32 before tick", v, 0);
    step(1);
    rd(A_CNT, v); check("R5 div32 tick", v, 1);

    // R5 divisor 512
    wr(A_CTRL, 16'h0000);
    wr(A_CLK, 16'd6);
    wr(A_CTRL, 16'h0001);
    step(511);
    rd(A_CNT, v); check("R5 div512 before tick", v, 0);
    step(1);
    rd(A_CNT, v); check("R5 div512 tick", v, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule